// File: doc/BRIEF.md
# Clock-Control Register Bank with Interrupt Flags

This block holds the software-visible state of a clock and reset controller. It has oscillator control and trim, the main clock configuration, three PLL setup words, interrupt enable/flag/clear, the peripheral reset, clock-enable and sleep-enable word groups, a kernel-clock source select, a backup-domain control word and a status/control word. It sits on a simple 32-bit register bus that decodes a 1 KB window. It drives a single level-sensitive interrupt.

The block only stores and returns values. Oscillators, PLL lock, clock gating and the actual peripheral resets are left to the logic that consumes these words. Hardware events set interrupt flags through a dedicated input. Software clears a flag only by writing a one to the matching bit of a separate clear register. Some bits are protected: read-only bits keep their value through any write, and set-only bits stay at 1 once they are 1.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset, reads return: word 0 = 0x00000063, word 1 = 0x106E0082, words 3..5 = 0x00001000, word 15 = 0x00000100, word 29 = 0x0C000600, sleep words 21..26 = 0x00011303, 0x000532FF, 0x00000101, 0xF2FECA3F, 0x00000025, 0x01677C01, and every other word = 0.
- R2: The bus decodes word index = address[9:2], with 30 words in this order:
  - 0 control, 1 calibration, 2 configuration, 3..5 PLL setups;
  - 6 interrupt enable, 7 flags, 8 clear;
  - 9..14 reset words, 15..20 clock-enable words (20 is the last), 21..26 sleep-enable words;
  - 27 clock select, 28 backup control, 29 status.
- R3: An access with address[1:0] != 0 or word index >= 30 changes nothing. One cycle after the access it pulses bus_err high for one cycle, and a read of that kind returns 0.
- R4: A write to word 0 leaves the read-only bits (mask 0x2A0A0402) unchanged. Bits in the set-only mask 0x00000101 that are 1 stay 1. All other bits take the written value.
- R5: A write to word 1, 2, 28 or 29 keeps the bits under that word's read-only mask and takes the written value elsewhere. The masks are 0x00FF00FF, 0x0000000C, 0x00000802 and 0xFF800000 respectively.
- R6: A write to word 20 ORs bit 0 of the old value into the written value, so bit 0 stays set once set.
- R7: Words 3..6, 9..19 and 21..27 take any written value unchanged.
- R8: A 1 on evt_set[k] (11 bits) sets flag bit k at the next clock edge. Word 7 bits 10:0 read the flags and bits 31:11 read 0.
- R9: Writes to word 7 have no effect on the flags.
- R10: Writing word 8 clears each flag bit whose data bit is 1. Word 8 always reads 0. If evt_set and a clear hit the same bit in the same cycle, the flag ends at 1.
- R11: irq is 1 exactly when the flags ANDed with the fixed mask 0x5FF are nonzero (flag bit 9 never raises irq). It follows the flags in the same cycle they update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse after a misaligned or unmapped access |
| evt_set | input | 11 | Hardware events that set interrupt flags |
| irq | output | 1 | Level interrupt |

## Verification
The case that needs care is a hardware event setting a flag in the same cycle that software writes the clear register for that bit. The event must win, and irq must stay at the value implied by the surviving flags. The bench provokes this directly on masked and unmasked bits. It also raises evt_set at random alongside random clear writes. After each access it compares the flag word and irq against a bench model that applies clear-then-set.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int NREG  = 30;
  localparam int IDX_W = 8;

  localparam int IX_CTRL  = 0;
  localparam int IX_CAL   = 1;
  localparam int IX_CFG   = 2;
  localparam int IX_FLAG  = 7;
  localparam int IX_CLR   = 8;
  localparam int IX_APB2E = 20;
  localparam int IX_BKUP  = 28;
  localparam int IX_STAT  = 29;

  localparam logic [31:0] CTRL_SO = 32'h0000_0101;
  localparam logic [31:0] APB2_SO = 32'h0000_0001;

  typedef enum logic [1:0] {
    WP_PLAIN,
    WP_KEEP_RO,
    WP_CTRL,
    WP_OR_SO
  } wpol_e;

  function automatic wpol_e policy(input int i);
    case (i)
      IX_CTRL:                          return WP_CTRL;
      IX_CAL, IX_CFG, IX_BKUP, IX_STAT: return WP_KEEP_RO;
      IX_APB2E:                         return WP_OR_SO;
      default:                          return WP_PLAIN;
    endcase
  endfunction

  function automatic logic [31:0] ro_mask(input int i);
    case (i)
      IX_CTRL: return 32'h2A0A_0402;
      IX_CAL:  return 32'h00FF_00FF;
      IX_CFG:  return 32'h0000_000C;
      IX_BKUP: return 32'h0000_0802;
      IX_STAT: return 32'hFF80_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] rst_val(input int i);
    case (i)
      0:       return 32'h0000_0063;
      1:       return 32'h106E_0082;
      3, 4, 5: return 32'h0000_1000;
      15:      return 32'h0000_0100;
      21:      return 32'h0001_1303;
      22:      return 32'h0005_32FF;
      23:      return 32'h0000_0101;
      24:      return 32'hF2FE_CA3F;
      25:      return 32'h0000_0025;
      26:      return 32'h0167_7C01;
      29:      return 32'h0C00_0600;
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;

  always_comb begin
    widx    = addr[ADDR_W-1:2];
    aligned = (addr[1:0] == 2'b00);
    idx     = IDX_W'(widx);
    hit     = aligned && (int'(widx) < NREG);
  end
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
  import clkctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [31:0]           wdata,
  output logic [NREG-1:0][31:0] regs_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_word
    if (i == IX_FLAG || i == IX_CLR) begin : g_hole
      assign regs_q[i] = 32'h0;
    end else begin : g_reg
      localparam logic [31:0] RO  = ro_mask(i);
      localparam wpol_e       POL = policy(i);
      logic [31:0] q, d;
      logic        ce;

      always_comb begin
        ce = wr_en && (wr_idx == IDX_W'(i));
        case (POL)
          WP_CTRL:    d = (q & (RO | CTRL_SO)) | (wdata & ~RO);
          WP_KEEP_RO: d = (q & RO) | (wdata & ~RO);
          WP_OR_SO:   d = (q & APB2_SO) | wdata;
          default:    d = wdata;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= rst_val(i);
        else if (ce) q <= d;
      end

      assign regs_q[i] = q;
    end
  end

  // R4: protected control bits
  assert_ctrl_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs_q[IX_CTRL] & ro_mask(IX_CTRL)));
  assert_ctrl_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[IX_CTRL][0] |=> regs_q[IX_CTRL][0]);
  // R6: set-only enable bit
  assert_apb2_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[IX_APB2E][0] |=> regs_q[IX_APB2E][0]);
endmodule

// File: rtl/clkctl_intc.sv
module clkctl_intc #(
  parameter int              FLAG_W   = 11,
  parameter logic [FLAG_W-1:0] INT_MASK = 11'h5FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_bits,
  input  logic [FLAG_W-1:0] evt_set,
  output logic [FLAG_W-1:0] flags,
  output logic              irq
);
  logic [FLAG_W-1:0] clr_eff, flags_d;

  always_comb begin
    clr_eff = clr_we ? clr_bits : '0;
    flags_d = (flags & ~clr_eff) | evt_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  assign irq = |(flags & INT_MASK);

  assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((flags & $past(evt_set)) == $past(evt_set)));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((flags & $past(clr_bits & ~evt_set)) == '0));
  assert_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_set & INT_MASK)) |=> irq);
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
#(
  parameter int                ADDR_W   = 10,
  parameter int                FLAG_W   = 11,
  parameter logic [FLAG_W-1:0] INT_MASK = 11'h5FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [FLAG_W-1:0] evt_set,
  output logic              irq
);
  logic [IDX_W-1:0]      idx;
  logic                  hit, wr_en, rd_en, clr_we;
  logic [NREG-1:0][31:0] regs_q;
  logic [FLAG_W-1:0]     flags;
  logic [31:0]           rd_word, rdata_d;
  logic                  err_d;

  clkctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .idx(idx), .hit(hit)
  );

  assign wr_en  = bus_en && bus_we && hit;
  assign rd_en  = bus_en && !bus_we;
  assign clr_we = wr_en && (idx == IDX_W'(IX_CLR));

  clkctl_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx),
    .wdata(bus_wdata), .regs_q(regs_q)
  );

  clkctl_intc #(.FLAG_W(FLAG_W), .INT_MASK(INT_MASK)) u_intc (
    .clk(clk), .rst_n(rst_n), .clr_we(clr_we),
    .clr_bits(bus_wdata[FLAG_W-1:0]), .evt_set(evt_set),
    .flags(flags), .irq(irq)
  );

  always_comb begin
    rd_word = 32'h0;
    if (hit) begin
      if (idx == IDX_W'(IX_FLAG)) rd_word = 32'(flags);
      else                        rd_word = regs_q[idx[4:0]];
    end
    rdata_d = rd_en ? rd_word : bus_rdata;
    err_d   = bus_en && !hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= 32'h0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      bus_err   <= err_d;
    end
  end

  assert_err_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && $past(rd_en)) |-> (bus_rdata == 32'h0));
  assert_clr_reads0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit && idx == IDX_W'(IX_CLR)) |=> (bus_rdata == 32'h0));
  assert_flagwr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(IX_FLAG) && evt_set == '0) |=> $stable(flags));
endmodule

// File: tb/clkctl_regbank_bench.sv
module clkctl_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [10:0] evt_set = '0;
  logic        irq;

  int nvec = 0, nbad = 0;
  logic [31:0] mdl [30];
  logic [10:0] mflags = '0;

  always #2.5 clk = ~clk;

  clkctl_regbank u_clkctl_regbank (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .evt_set(evt_set), .irq(irq)
  );

  function automatic logic [31:0] exp_rst(int i);
    case (i)
      0: return 32'h63; 1: return 32'h106E0082;
      3, 4, 5: return 32'h1000; 15: return 32'h100;
      21: return 32'h00011303; 22: return 32'h000532FF; 23: return 32'h101;
      24: return 32'hF2FECA3F; 25: return 32'h25; 26: return 32'h01677C01;
      29: return 32'h0C000600; default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_wr(int i, logic [31:0] o, logic [31:0] v);
    case (i)
      0:  return (o & (32'h2A0A0402 | 32'h101)) | (v & ~32'h2A0A0402);
      1:  return (o & 32'h00FF00FF) | (v & ~32'h00FF00FF);
      2:  return (o & 32'hC) | (v & ~32'hC);
      28: return (o & 32'h802) | (v & ~32'h802);
      29: return (o & 32'hFF800000) | (v & ~32'hFF800000);
      20: return (o & 32'h1) | v;
      default: return v;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(string req, logic we, logic [9:0] a, logic [31:0] d, logic [10:0] ev);
    int  w = int'(a[9:2]);
    bit  hit = (a[1:0] == 2'b00) && (w < 30);
    logic [31:0] rexp = 32'h0;
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; evt_set = ev;
    if (hit && !we) rexp = (w == 7) ? 32'(mflags) : mdl[w];
    @(posedge clk); #1;
    bus_en = 1'b0; evt_set = '0;
    if (hit && we && w != 7 && w != 8) mdl[w] = exp_wr(w, mdl[w], d);
    if (hit && we && w == 8) mflags = mflags & ~d[10:0];
    mflags = mflags | ev;
    check({req, " err"}, 32'(bus_err), 32'(!hit));
    if (!we) check({req, " rdata"}, bus_rdata, rexp);
    check({req, " irq R11"}, 32'(irq), 32'(|(mflags & 11'h5FF)));
  endtask

  initial begin
    for (int i = 0; i < 30; i++) mdl[i] = exp_rst(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq reset", 32'(irq), 32'h0);
    for (int i = 0; i < 30; i++) op("R1 R2 reset read", 1'b0, 10'(i * 4), 0, 0);
    // R4 control protection
    op("R4 ctrl wr", 1'b1, 10'h000, 32'h0000_0000, 0);
    op("R4 ctrl rd", 1'b0, 10'h000, 0, 0);
    op("R4 ctrl wr", 1'b1, 10'h000, 32'hFFFF_FFFF, 0);
    op("R4 ctrl rd", 1'b0, 10'h000, 0, 0);
    op("R4 ctrl wr", 1'b1, 10'h000, 32'h0, 0);
    op("R4 ctrl rd", 1'b0, 10'h000, 0, 0);
    // R5 read-only fields
    for (int i = 1; i < 3; i++) begin
      op("R5 wr", 1'b1, 10'(i * 4), 32'hA5A5_5A5A, 0);
      op("R5 rd", 1'b0, 10'(i * 4), 0, 0);
    end
    op("R5 wr", 1'b1, 10'h070, 32'h0, 0);
    op("R5 rd", 1'b0, 10'h070, 0, 0);
    op("R5 wr", 1'b1, 10'h074, 32'h0, 0);
    op("R5 rd", 1'b0, 10'h074, 0, 0);
    // R6 sticky enable
    op("R6 wr", 1'b1, 10'h050, 32'h1, 0);
    op("R6 wr", 1'b1, 10'h050, 32'h0, 0);
    op("R6 rd", 1'b0, 10'h050, 0, 0);
    // R7 plain
    op("R7 wr", 1'b1, 10'h060, 32'hDEAD_BEEF, 0);
    op("R7 rd", 1'b0, 10'h060, 0, 0);
    // R3 misaligned and unmapped
    op("R3 mis wr", 1'b1, 10'h062, 32'h0, 0);
    op("R3 rd", 1'b0, 10'h060, 0, 0);
    op("R3 mis rd", 1'b0, 10'h001, 0, 0);
    op("R3 unmap wr", 1'b1, 10'h078, 32'h1234, 0);
    op("R3 unmap rd", 1'b0, 10'h3FC, 0, 0);
    // R8 R9 R10 R11 flags
    op("R8 set", 1'b0, 10'h01C, 0, 11'h200);
    op("R11 masked", 1'b0, 10'h01C, 0, 0);
    op("R9 flag wr", 1'b1, 10'h01C, 32'h0, 0);
    op("R9 rd", 1'b0, 10'h01C, 0, 0);
    op("R8 set", 1'b0, 10'h01C, 0, 11'h003);
    op("R10 clr", 1'b1, 10'h020, 32'h1, 0);
    op("R10 clr rd", 1'b0, 10'h020, 0, 0);
    op("R10 race", 1'b1, 10'h020, 32'h7FF, 11'h002);
    op("R10 race rd", 1'b0, 10'h01C, 0, 0);
    op("R10 clr all", 1'b1, 10'h020, 32'hFFFF_FFFF, 0);
    op("R11 rd", 1'b0, 10'h01C, 0, 0);
    // random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 600; n++) begin
      logic [9:0]  a;
      logic [10:0] ev;
      int sel = $urandom_range(0, 9);
      a = (sel == 0) ? 10'($urandom) : 10'($urandom_range(0, 29) * 4);
      if (sel == 1) a = 10'h020;
      ev = ($urandom_range(0, 3) == 0) ? 11'($urandom) : 11'h0;
      op("R2 R8 R10 rand", 1'($urandom), a, $urandom, ev);
    end
    for (int i = 0; i < 30; i++) op("R2 final", 1'b0, 10'(i * 4), 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule